// File: doc/BRIEF.md
# Packed Short-Instruction Fetch and Decode

This block sits between instruction memory and the controller of a small processor. It holds one fetched 16-bit word and presents its contents as the current instruction. A word holds either one long instruction or two short ones. A long instruction is an opcode and register selects followed by an 8-bit immediate. The short instructions are 8 bits each and run one after the other. The block pulls out the opcode, destination select, source select and immediate of the current instruction. It also tells the controller whether a new memory word is needed before the next instruction can run.

The controller pulses the load strobe when a new word arrives on the memory data input. It pulses the advance strobe when the current instruction has retired. After a load, the upper byte is the current instruction. If the upper byte is short and the lower byte holds a real instruction, an advance moves to the lower byte without any memory access. A lower byte of all zeros counts as a no-operation filler, so the word is treated as used up once the upper byte has run. While halt is high the register and the slot pointer hold their values, so the last fetched instruction stays visible.

Top module: `ifd_packed_fetch`

## Requirements
- R1: While reset is asserted, and afterwards until the first load, the word register is zero and the upper slot is current. The outputs are then: opcode 0, destination 0, source 0, immediate 0, long flag 0, fetch request 1.
- R2: The cycle after a load with halt low, the upper byte is current. The opcode is word bits [15:12], the destination select is bits [11:10] and the source select is bits [9:8]. The destination and source fields pass through unchanged, so the controller can use them as opcode extension bits.
- R3: An upper byte whose opcode is 4'b1111 is a long instruction. The long flag is 1, the immediate output equals word bits [7:0] and the fetch request is 1. An advance without a load leaves every output unchanged.
- R4: When the upper byte is short and the lower byte is not 8'h00, the fetch request is 0 while the upper byte is current. An advance then presents the lower byte: opcode bits [7:4], destination bits [3:2], source bits [1:0], long flag 0 and fetch request 1. This holds even if bits [7:4] are 4'b1111.
- R5: When the upper byte is short and the lower byte is 8'h00, the fetch request is 1 while the upper byte is current. An advance without a load leaves every output unchanged.
- R6: While halt is high, load and advance have no effect, and all outputs keep their values.
- R7: When load and advance are both high with halt low, the load wins. The new word's upper byte becomes current.
- R8: When the lower slot is current, an advance without a load leaves every output unchanged. The immediate output is 0 for every short instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_word_i | input | 16 | Instruction word from memory |
| load_i | input | 1 | Capture mem_word_i and select the upper slot |
| advance_i | input | 1 | Current instruction retired; step to the lower slot if one is pending |
| halt_i | input | 1 | Freeze the register and the slot pointer |
| opcode_o | output | 4 | Opcode of the current instruction |
| dst_sel_o | output | 2 | Destination register select (R0..R3) or extension bits |
| src_sel_o | output | 2 | Source register select (R0..R3) or extension bits |
| imm_o | output | 8 | Immediate of a long instruction, otherwise 0 |
| is_long_o | output | 1 | Current instruction is long |
| fetch_req_o | output | 1 | Current instruction is the last one in the word; load a new word next |

## Verification
All outputs are decoded combinationally from the word register and the slot pointer. The effect of a load or advance strobe therefore shows at the outputs after exactly one rising edge, and not earlier. The bench drives each strobe at a falling edge and samples a quarter period after the next rising edge. This is after the register has updated and before the next stimulus is driven. Asynchronous reset is checked a short delay after it is asserted, with no clock edge in between. The hold cases (halt, an exhausted word, and an idle cycle) are checked at the same sampling point, so any change one edge later would be caught.

// File: rtl/ifd_pkg.sv
package ifd_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned SLOT_W = WORD_W / 2;
  localparam int unsigned OPC_W  = 4;
  localparam int unsigned SEL_W  = 2;

  localparam logic [OPC_W-1:0]  LONG_OPC  = '1;
  localparam logic [SLOT_W-1:0] NOP_SLOT  = '0;

  typedef enum logic {
    SLOT_HI = 1'b0,
    SLOT_LO = 1'b1
  } slot_e;
endpackage

// File: rtl/ifd_ir_store.sv
module ifd_ir_store
  import ifd_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] word_i,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         halt_i,
  output logic [W-1:0] ir_o,
  output slot_e        slot_o
);
  logic [W-1:0] ir_q;
  slot_e        slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q   <= '0;
      slot_q <= SLOT_HI;
    end else if (!halt_i) begin
      if (load_i) begin
        ir_q   <= word_i;
        slot_q <= SLOT_HI;
      end else if (step_i) begin
        slot_q <= SLOT_LO;
      end
    end
  end

  assign ir_o   = ir_q;
  assign slot_o = slot_q;

  // R6
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> ($stable(ir_q) && $stable(slot_q)));

  // R7
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !halt_i) |=> (slot_q == SLOT_HI && ir_q == $past(word_i)));
endmodule

// File: rtl/ifd_slot_decode.sv
module ifd_slot_decode
  import ifd_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned SW = W / 2,
  parameter int unsigned OW = OPC_W,
  parameter int unsigned RW = SEL_W
) (
  input  logic [W-1:0]  ir_i,
  input  slot_e         slot_i,
  output logic [OW-1:0] opcode_o,
  output logic [RW-1:0] dst_o,
  output logic [RW-1:0] src_o,
  output logic [SW-1:0] imm_o,
  output logic          long_o,
  output logic          last_o
);
  logic [SW-1:0] hi_byte, lo_byte, cur;
  logic          hi_long, lo_empty;

  assign hi_byte  = ir_i[W-1:SW];
  assign lo_byte  = ir_i[SW-1:0];
  assign hi_long  = (hi_byte[SW-1 -: OW] == LONG_OPC[OW-1:0]);
  assign lo_empty = (lo_byte == NOP_SLOT[SW-1:0]);

  always_comb begin
    cur      = (slot_i == SLOT_LO) ? lo_byte : hi_byte;
    opcode_o = cur[SW-1 -: OW];
    dst_o    = cur[RW*2-1 -: RW];
    src_o    = cur[RW-1:0];
    long_o   = (slot_i == SLOT_HI) && hi_long;
    imm_o    = long_o ? lo_byte : '0;
    // word exhausted after the current instruction
    last_o   = (slot_i == SLOT_LO) || hi_long || lo_empty;
  end
endmodule

// File: rtl/ifd_packed_fetch.sv
module ifd_packed_fetch
  import ifd_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned SW = W / 2,
  parameter int unsigned OW = OPC_W,
  parameter int unsigned RW = SEL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  mem_word_i,
  input  logic          load_i,
  input  logic          advance_i,
  input  logic          halt_i,
  output logic [OW-1:0] opcode_o,
  output logic [RW-1:0] dst_sel_o,
  output logic [RW-1:0] src_sel_o,
  output logic [SW-1:0] imm_o,
  output logic          is_long_o,
  output logic          fetch_req_o
);
  logic [W-1:0] ir;
  slot_e        slot;
  logic         last;
  logic         step;

  assign step = advance_i && !last;

  ifd_ir_store #(.W(W)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .word_i (mem_word_i),
    .load_i (load_i),
    .step_i (step),
    .halt_i (halt_i),
    .ir_o   (ir),
    .slot_o (slot)
  );

  ifd_slot_decode #(.W(W), .SW(SW), .OW(OW), .RW(RW)) u_decode (
    .ir_i     (ir),
    .slot_i   (slot),
    .opcode_o (opcode_o),
    .dst_o    (dst_sel_o),
    .src_o    (src_sel_o),
    .imm_o    (imm_o),
    .long_o   (is_long_o),
    .last_o   (last)
  );

  assign fetch_req_o = last;

  // R4
  lower_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slot == SLOT_LO) |-> $past(advance_i && !load_i && !halt_i));

  // R3
  long_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_long_o |-> (fetch_req_o && slot == SLOT_HI));

  // R5
  exhausted_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_o && advance_i && !load_i) |=>
      ($stable(opcode_o) && $stable(dst_sel_o) && $stable(src_sel_o) &&
       $stable(imm_o) && $stable(is_long_o)));
endmodule

// File: tb/ifd_packed_fetch_bench.sv
module ifd_packed_fetch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;
  // {req[3:0], load, adv, halt, word[15:0], opc[3:0], dst[1:0], src[1:0], imm[7:0], long, freq}
  localparam logic [40:0] TBL [0:NV-1] = '{
    {4'd2, 3'b100, 16'h5A3C, 4'h5, 2'd2, 2'd2, 8'h00, 1'b0, 1'b0}, // R2 short pair, upper
    {4'd4, 3'b010, 16'h0000, 4'h3, 2'd3, 2'd0, 8'h00, 1'b0, 1'b1}, // R4 step to lower
    {4'd8, 3'b010, 16'h0000, 4'h3, 2'd3, 2'd0, 8'h00, 1'b0, 1'b1}, // R8 advance in lower slot
    {4'd3, 3'b100, 16'hF7A5, 4'hF, 2'd1, 2'd3, 8'hA5, 1'b1, 1'b1}, // R3 long word
    {4'd3, 3'b010, 16'h0000, 4'hF, 2'd1, 2'd3, 8'hA5, 1'b1, 1'b1}, // R3 advance ignored
    {4'd3, 3'b100, 16'hF000, 4'hF, 2'd0, 2'd0, 8'h00, 1'b1, 1'b1}, // R3 long, zero immediate
    {4'd5, 3'b100, 16'h6E00, 4'h6, 2'd3, 2'd2, 8'h00, 1'b0, 1'b1}, // R5 filler lower byte
    {4'd5, 3'b010, 16'h0000, 4'h6, 2'd3, 2'd2, 8'h00, 1'b0, 1'b1}, // R5 advance ignored
    {4'd6, 3'b101, 16'h2147, 4'h6, 2'd3, 2'd2, 8'h00, 1'b0, 1'b1}, // R6 load under halt
    {4'd2, 3'b100, 16'h2147, 4'h2, 2'd0, 2'd1, 8'h00, 1'b0, 1'b0}, // R2 load
    {4'd6, 3'b011, 16'h0000, 4'h2, 2'd0, 2'd1, 8'h00, 1'b0, 1'b0}, // R6 advance under halt
    {4'd7, 3'b110, 16'h9BC4, 4'h9, 2'd2, 2'd3, 8'h00, 1'b0, 1'b0}, // R7 load beats advance
    {4'd4, 3'b010, 16'h0000, 4'hC, 2'd1, 2'd0, 8'h00, 1'b0, 1'b1}, // R4 lower slot
    {4'd8, 3'b000, 16'h0000, 4'hC, 2'd1, 2'd0, 8'h00, 1'b0, 1'b1}, // R8 idle holds
    {4'd4, 3'b100, 16'h1EF3, 4'h1, 2'd3, 2'd2, 8'h00, 1'b0, 1'b0}, // R4 upper short
    {4'd4, 3'b010, 16'h0000, 4'hF, 2'd0, 2'd3, 8'h00, 1'b0, 1'b1}  // R4 lower 1111 opcode is short
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] mem_word_i = '0;
  logic        load_i = 1'b0, advance_i = 1'b0, halt_i = 1'b0;
  logic [3:0]  opcode_o;
  logic [1:0]  dst_sel_o, src_sel_o;
  logic [7:0]  imm_o;
  logic        is_long_o, fetch_req_o;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ifd_packed_fetch u_ifd_packed_fetch (
    .clk_i, .rst_ni, .mem_word_i, .load_i, .advance_i, .halt_i,
    .opcode_o, .dst_sel_o, .src_sel_o, .imm_o, .is_long_o, .fetch_req_o
  );

  task automatic check(input int req, input logic [17:0] exp);
    logic [17:0] act;
    act = {opcode_o, dst_sel_o, src_sel_o, imm_o, is_long_o, fetch_req_o};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d act=%h exp=%h (opc,dst,src,imm,long,freq)", req, act, exp);
    end
  endtask

  initial begin
    // R1 reset state, asynchronous
    #(CLK_PERIOD*2 + 1);
    check(1, {4'h0, 2'd0, 2'd0, 8'h00, 1'b0, 1'b1});
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #(CLK_PERIOD/4);
    check(1, {4'h0, 2'd0, 2'd0, 8'h00, 1'b0, 1'b1}); // R1 held until first load
    @(negedge clk_i);
    for (int i = 0; i < NV; i++) begin
      {load_i, advance_i, halt_i} = TBL[i][36:34];
      mem_word_i = TBL[i][33:18];
      @(posedge clk_i); #(CLK_PERIOD/4);
      check(int'(TBL[i][40:37]), TBL[i][17:0]);
      @(negedge clk_i);
      {load_i, advance_i, halt_i} = 3'b000;
      mem_word_i = '0;
    end
    // R1 reset in mid-run clears a loaded word
    load_i = 1'b1; mem_word_i = 16'hF5C3;
    @(posedge clk_i); #(CLK_PERIOD/4);
    check(3, {4'hF, 2'd1, 2'd1, 8'hC3, 1'b1, 1'b1}); // R3
    @(negedge clk_i);
    load_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    check(1, {4'h0, 2'd0, 2'd0, 8'h00, 1'b0, 1'b1}); // R1
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R6 halt and load together, then release
    halt_i = 1'b1; load_i = 1'b1; mem_word_i = 16'h4D81;
    @(posedge clk_i); #(CLK_PERIOD/4);
    check(6, {4'h0, 2'd0, 2'd0, 8'h00, 1'b0, 1'b1});
    @(negedge clk_i);
    halt_i = 1'b0;
    @(posedge clk_i); #(CLK_PERIOD/4);
    check(2, {4'h4, 2'd3, 2'd1, 8'h00, 1'b0, 1'b0}); // R2
    @(negedge clk_i);
    load_i = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule